// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block times the serial clock of an I2C bus master. It counts down a programmable reload value with an enable that runs at half the system clock rate. Each count that reaches zero ends one half of the SCL period. The low half drives the line low. The high half begins only after the released line has been read high. As a result, a slave that stretches the clock, or a second master that holds SCL low, lengthens the high half without cutting it short. A one-cycle pulse marks the end of every half period, so a bit-level controller can step its shift and acknowledge logic from it.

The reload register is eight bits wide. A mode input chooses between two reload widths:

- **Narrow mode:** only the low seven bits of the register are used and the top bit is discarded.
- **Wide mode:** all eight bits are used.

Values below three cannot produce a working bus. Such a value is replaced by three, and a sticky flag records that it happened. With reload value R, each half period lasts 2·(R+1) system clocks, so one SCL period lasts 4·(R+1) clocks. For example, R = 0x9F in wide mode gives 640 clocks per period, which is 50 kHz from a 32 MHz system clock.

Top module: `scl_rate_gen`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), scl_drive_low, phase_tick and bad_reload_flag are all 0.
- R2: While enable is 0, scl_drive_low is 0 from the next cycle on and phase_tick stays 0. Clearing enable in the middle of a phase releases SCL in the following cycle.
- R3: When enable is first seen high at a rising edge, scl_drive_low goes to 1 in the next cycle. Each low phase lasts exactly 2·(R+1) clock cycles, where R is the effective reload value.
- R4: After release, once scl_in reads high, SCL stays released for 2·(R+1) cycles during which scl_in is high. scl_drive_low then returns to 1 in the next cycle. With no stretching, one full period is 4·(R+1) cycles.
- R5: When wide_mode is 0, bit 7 of reload_val is ignored and R = reload_val[6:0]. When wide_mode is 1, R = reload_val[7:0]. For reload_val = 0x9F this gives 64-cycle phases in narrow mode and 320-cycle phases in wide mode.
- R6: An effective value of 0, 1 or 2 is used as 3, giving 8-cycle phases, and sets bad_reload_flag. The flag stays 1 until the next reset, even after a valid value is programmed.
- R7: While SCL is released but scl_in reads low (the line is stretched), the count stalls and phase_tick stays 0. The high phase is still timed in full from the first cycle scl_in reads high.
- R8: phase_tick is a single-cycle pulse. It is high in the last cycle of each low phase (the last cycle with scl_drive_low = 1) and in the last cycle of each high phase. It appears exactly once per phase.
- R9: The counter samples reload_val only at a reload, meaning the start of a phase, so a change made during a count affects only the next phase. The value present at the edge that starts a phase is the one used, even if it changed in that very cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reload_val | input | 8 | Reload register contents |
| wide_mode | input | 1 | 1: use all 8 bits; 0: use bits 6:0 only |
| enable | input | 1 | Runs the generator; 0 holds the counter and releases SCL |
| scl_in | input | 1 | Synchronised level read from the SCL line |
| scl_drive_low | output | 1 | 1 requests the pad to pull SCL low |
| phase_tick | output | 1 | One-cycle pulse at the end of each half period |
| bad_reload_flag | output | 1 | Sticky: a reload value below 3 was used |

## Verification
The collision of interest is a new reload value arriving in the very cycle a phase ends, when the counter is reloaded. The bench waits for the tick that closes a high phase and changes reload_val in that same cycle, before the edge. It then requires the following low and high phases to have the new length. A second case changes the value partway through a low phase and requires the current phase to keep the old length while the next high phase takes the new one. Stretching is provoked by holding the modelled bus low after release: the bench requires no tick during the hold and a full-length high phase afterwards.

// File: rtl/srg_pkg.sv
// Package: shared types for the SCL rate generator.
// Assumes: nothing beyond IEEE 1800-2017.
package srg_pkg;

    // Phase of the generated clock
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // disabled, SCL released, counter held
        PH_LOW  = 2'd1,   // driving SCL low, counting
        PH_WAIT = 2'd2,   // released, waiting to read SCL high
        PH_HIGH = 2'd3    // released and high, counting
    } srg_phase_e;

endpackage

// File: rtl/srg_reload_sel.sv
// Module: reload value selection.
// Masks the raw register down to its narrow width unless wide mode is set,
// then raises values below MIN_RELOAD to MIN_RELOAD and flags that case.
// Assumes: NARROW_W <= CNT_W and MIN_RELOAD fits in CNT_W bits.
module srg_reload_sel #(
    parameter int CNT_W      = 8,
    parameter int NARROW_W   = 7,
    parameter int MIN_RELOAD = 3
) (
    input  logic [CNT_W-1:0] raw_val,
    input  logic             wide_mode,
    output logic [CNT_W-1:0] eff_val,
    output logic             clamped
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_RELOAD);

    logic [CNT_W-1:0] masked;

    generate
        if (NARROW_W >= CNT_W) begin : g_no_mask
            // Narrow width covers the whole register: nothing to strip
            assign masked = raw_val;
        end else begin : g_mask
            localparam logic [CNT_W-1:0] NARROW_MASK =
                {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
            // Strip the upper bits in narrow mode
            assign masked = wide_mode ? raw_val : (raw_val & NARROW_MASK);
        end
    endgenerate

    // Raise too-small values to the floor
    always_comb begin
        clamped = (masked < FLOOR);
        eff_val = clamped ? FLOOR : masked;
    end

endmodule

// File: rtl/srg_prescale.sv
// Module: half-rate count enable.
// Produces a count enable every second cycle. A restart forces the phase of
// the enable so that every half period starts with a known alignment.
// Assumes: restart has priority over free running.
module srg_prescale (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic restart_val,
    output logic cnt_en
);
    logic phase_q;

    // Toggle every cycle, or jump to the requested phase on restart
    always_ff @(posedge clk) begin
        if (!rst_n)       phase_q <= 1'b0;
        else if (restart) phase_q <= restart_val;
        else              phase_q <= ~phase_q;
    end

    assign cnt_en = phase_q;

endmodule

// File: rtl/srg_down_counter.sv
// Module: loadable down-counter.
// Loads a value on request, otherwise decrements on the count enable and
// stops at zero.
// Assumes: load has priority over decrement.
module srg_down_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             is_zero
);
    logic [CNT_W-1:0] cnt_q;

    // Load, or count down to zero and stop there
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (load)                    cnt_q <= load_val;
        else if (dec && (cnt_q != '0))    cnt_q <= cnt_q - 1'b1;
    end

    assign is_zero = (cnt_q == '0);

endmodule

// File: rtl/srg_phase_ctrl.sv
// Module: phase sequencer.
// Steps IDLE -> LOW -> WAIT -> HIGH -> LOW ... and decides when the counter
// reloads and when the prescaler restarts. HIGH starts with the count enable
// already asserted, so that the cycle spent reading SCL high in WAIT counts
// toward the high half.
// Assumes: scl_in is already synchronised to clk.
module srg_phase_ctrl
    import srg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_in,
    input  logic cnt_en,
    input  logic cnt_zero,
    output logic ld_cnt,
    output logic pre_restart,
    output logic pre_val,
    output logic tick,
    output logic drive_low
);
    srg_phase_e state_q, state_d;

    logic phase_done;

    // A counting phase ends when the enable hits a zero count
    assign phase_done = enable && cnt_en && cnt_zero &&
                        ((state_q == PH_LOW) || (state_q == PH_HIGH));

    // Next state, counter reload and prescaler restart
    always_comb begin
        state_d     = state_q;
        ld_cnt      = 1'b0;
        pre_restart = 1'b0;
        pre_val     = 1'b0;
        if (!enable) begin
            state_d     = PH_IDLE;
            ld_cnt      = 1'b1;
            pre_restart = 1'b1;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    state_d     = PH_LOW;
                    ld_cnt      = 1'b1;
                    pre_restart = 1'b1;
                end
                PH_LOW: begin
                    if (phase_done) state_d = PH_WAIT;
                end
                PH_WAIT: begin
                    if (scl_in) begin
                        state_d     = PH_HIGH;
                        ld_cnt      = 1'b1;
                        pre_restart = 1'b1;
                        pre_val     = 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (phase_done) begin
                        state_d     = PH_LOW;
                        ld_cnt      = 1'b1;
                        pre_restart = 1'b1;
                    end
                end
                default: state_d = PH_IDLE;
            endcase
        end
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    assign tick      = phase_done;
    assign drive_low = (state_q == PH_LOW);

endmodule

// File: rtl/scl_rate_gen.sv
// Module: top of the SCL rate generator.
// Joins reload selection, half-rate prescaler, down-counter and phase
// sequencer, and keeps the sticky flag for out-of-range reload values.
// Assumes: scl_in is synchronised; pad logic turns scl_drive_low into an
// open-drain pull-down.
module scl_rate_gen #(
    parameter int CNT_W      = 8,
    parameter int NARROW_W   = 7,
    parameter int MIN_RELOAD = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             wide_mode,
    input  logic             enable,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             phase_tick,
    output logic             bad_reload_flag
);
    logic [CNT_W-1:0] eff_val;
    logic             clamped;
    logic             cnt_en;
    logic             cnt_zero;
    logic             ld_cnt;
    logic             pre_restart;
    logic             pre_val;
    logic             bad_q;

    srg_reload_sel #(
        .CNT_W      (CNT_W),
        .NARROW_W   (NARROW_W),
        .MIN_RELOAD (MIN_RELOAD)
    ) u_sel (
        .raw_val   (reload_val),
        .wide_mode (wide_mode),
        .eff_val   (eff_val),
        .clamped   (clamped)
    );

    srg_prescale u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (pre_restart),
        .restart_val (pre_val),
        .cnt_en      (cnt_en)
    );

    srg_down_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_cnt),
        .load_val (eff_val),
        .dec      (cnt_en),
        .is_zero  (cnt_zero)
    );

    srg_phase_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .scl_in      (scl_in),
        .cnt_en      (cnt_en),
        .cnt_zero    (cnt_zero),
        .ld_cnt      (ld_cnt),
        .pre_restart (pre_restart),
        .pre_val     (pre_val),
        .tick        (phase_tick),
        .drive_low   (scl_drive_low)
    );

    // Sticky record of any reload that needed raising to the floor
    always_ff @(posedge clk) begin
        if (!rst_n)                 bad_q <= 1'b0;
        else if (ld_cnt && clamped) bad_q <= 1'b1;
    end

    assign bad_reload_flag = bad_q;

endmodule

// File: rtl/scl_rate_gen_chk.sv
// Module: property checker for scl_rate_gen, attached with bind.
// Assumes: observes top-level ports only.
module scl_rate_gen_chk #(
    parameter int CNT_W      = 8,
    parameter int NARROW_W   = 7,
    parameter int MIN_RELOAD = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] reload_val,
    input logic             wide_mode,
    input logic             enable,
    input logic             scl_in,
    input logic             scl_drive_low,
    input logic             phase_tick,
    input logic             bad_reload_flag
);
    logic [CNT_W-1:0] seen_val;

    // Value the port settings select, for relating the flag to its cause
    always_comb begin
        seen_val = reload_val;
        if (!wide_mode && (NARROW_W < CNT_W))
            seen_val = reload_val & CNT_W'((1 << NARROW_W) - 1);
    end

    a_r8_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        phase_tick |=> !phase_tick);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_drive_low && !phase_tick));

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        bad_reload_flag |=> bad_reload_flag);

    a_r6_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bad_reload_flag) |-> ($past(seen_val) < CNT_W'(MIN_RELOAD)));

    a_r3_low_end_release: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_tick && scl_drive_low) |=> !scl_drive_low);

    a_r4_high_end_pull: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_tick && !scl_drive_low && enable) |=> scl_drive_low);

    a_r7_no_tick_stretched: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_drive_low && !scl_in) |-> !phase_tick);

endmodule

bind scl_rate_gen scl_rate_gen_chk #(
    .CNT_W      (CNT_W),
    .NARROW_W   (NARROW_W),
    .MIN_RELOAD (MIN_RELOAD)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .reload_val      (reload_val),
    .wide_mode       (wide_mode),
    .enable          (enable),
    .scl_in          (scl_in),
    .scl_drive_low   (scl_drive_low),
    .phase_tick      (phase_tick),
    .bad_reload_flag (bad_reload_flag)
);

// File: tb/scl_rate_gen_tb.sv
// Bench: directed scenarios, one task each, checks made inside each task.
module scl_rate_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reload_val = 8'd9;
    logic       wide_mode = 1'b1;
    logic       enable = 1'b0;
    logic       stretch = 1'b0;
    logic       scl_bus;
    logic       scl_drive_low;
    logic       phase_tick;
    logic       bad_reload_flag;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    // Open-drain bus with pull-up: low if the block or a stretching slave pulls
    assign scl_bus = !scl_drive_low && !stretch;

    scl_rate_gen u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .reload_val      (reload_val),
        .wide_mode       (wide_mode),
        .enable          (enable),
        .scl_in          (scl_bus),
        .scl_drive_low   (scl_drive_low),
        .phase_tick      (phase_tick),
        .bad_reload_flag (bad_reload_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; enable = 1'b0; stretch = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Measure one low phase and the released-high phase after it.
    // Call at a negedge; returns at the negedge of the next low phase's first cycle.
    task automatic meas(output int lo, output int hi, output int lo_tk, output int hi_tk,
                        output int lo_last, output int hi_last);
        int guard = 0;
        lo = 0; hi = 0; lo_tk = 0; hi_tk = 0; lo_last = 0; hi_last = 0;
        while (!scl_drive_low && guard < 4000) begin @(negedge clk); guard++; end
        while (scl_drive_low && guard < 4000) begin
            lo++; lo_tk += int'(phase_tick); lo_last = int'(phase_tick);
            @(negedge clk); guard++;
        end
        while (!scl_drive_low && guard < 4000) begin
            if (scl_bus) begin
                hi++; hi_last = int'(phase_tick);
            end
            hi_tk += int'(phase_tick);
            @(negedge clk); guard++;
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 drive_low after reset", int'(scl_drive_low), 0);
        check("R1 tick after reset", int'(phase_tick), 0);
        check("R1 flag after reset", int'(bad_reload_flag), 0);
    endtask

    task automatic t_disabled();
        int drv = 0, tk = 0;
        do_reset();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); drv += int'(scl_drive_low); tk += int'(phase_tick);
        end
        check("R2 idle drive_low cycles", drv, 0);
        check("R2 idle tick cycles", tk, 0);
        reload_val = 8'd9; wide_mode = 1'b1; enable = 1'b1;
        repeat (5) @(negedge clk);
        check("R2 running low before disable", int'(scl_drive_low), 1);
        enable = 1'b0;
        @(negedge clk);
        check("R2 released one cycle after disable", int'(scl_drive_low), 0);
    endtask

    task automatic t_basic();
        int lo, hi, lt, ht, ll, hl;
        do_reset();
        reload_val = 8'd9; wide_mode = 1'b1;
        enable = 1'b1;
        @(negedge clk);
        check("R3 low one cycle after enable", int'(scl_drive_low), 1);
        meas(lo, hi, lt, ht, ll, hl);
        check("R3 low length R=9", lo, 20);
        check("R4 high length R=9", hi, 20);
        check("R8 one tick in low", lt, 1);
        check("R8 tick on last low cycle", ll, 1);
        check("R8 one tick in high", ht, 1);
        check("R8 tick on last high cycle", hl, 1);
        meas(lo, hi, lt, ht, ll, hl);
        check("R4 period R=9", lo + hi, 40);
        check("R6 flag clear for valid value", int'(bad_reload_flag), 0);
    endtask

    task automatic t_modes();
        int lo, hi, lt, ht, ll, hl;
        do_reset();
        reload_val = 8'h9F; wide_mode = 1'b0; enable = 1'b1;
        meas(lo, hi, lt, ht, ll, hl);
        check("R5 narrow 0x9F low", lo, 64);
        check("R5 narrow 0x9F high", hi, 64);
        do_reset();
        reload_val = 8'h9F; wide_mode = 1'b1; enable = 1'b1;
        meas(lo, hi, lt, ht, ll, hl);
        check("R5 wide 0x9F period", lo + hi, 640);
    endtask

    task automatic t_clamp();
        int lo, hi, lt, ht, ll, hl;
        do_reset();
        reload_val = 8'd1; wide_mode = 1'b1; enable = 1'b1;
        meas(lo, hi, lt, ht, ll, hl);
        check("R6 value 1 low", lo, 8);
        check("R6 value 1 high", hi, 8);
        check("R6 flag set", int'(bad_reload_flag), 1);
        reload_val = 8'd10;
        meas(lo, hi, lt, ht, ll, hl);
        meas(lo, hi, lt, ht, ll, hl);
        check("R6 valid value after clamp", lo, 22);
        check("R6 flag sticky", int'(bad_reload_flag), 1);
        do_reset();
        check("R1 flag cleared by reset", int'(bad_reload_flag), 0);
        reload_val = 8'h82; wide_mode = 1'b0; enable = 1'b1;
        meas(lo, hi, lt, ht, ll, hl);
        check("R6 narrow 0x82 low", lo, 8);
        check("R6 narrow 0x82 flag", int'(bad_reload_flag), 1);
    endtask

    task automatic t_stretch();
        int tk = 0, hi = 0, hl = 0, guard = 0;
        do_reset();
        reload_val = 8'd5; wide_mode = 1'b1; enable = 1'b1;
        while (!scl_drive_low && guard < 100) begin @(negedge clk); guard++; end
        stretch = 1'b1;
        while (scl_drive_low && guard < 100) begin @(negedge clk); guard++; end
        for (int i = 0; i < 15; i++) begin
            tk += int'(phase_tick);
            @(negedge clk);
        end
        check("R7 no tick while stretched", tk, 0);
        check("R7 no pull while stretched", int'(scl_drive_low), 0);
        stretch = 1'b0;
        #1;
        while (!scl_drive_low && guard < 200) begin
            if (scl_bus) begin hi++; hl = int'(phase_tick); end
            @(negedge clk); guard++;
        end
        check("R7 full high after stretch", hi, 12);
        check("R7 tick ends stretched high", hl, 1);
    endtask

    task automatic t_midchange();
        int lo, hi, lt, ht, ll, hl;
        do_reset();
        reload_val = 8'd9; wide_mode = 1'b1; enable = 1'b1;
        fork
            meas(lo, hi, lt, ht, ll, hl);
            begin repeat (6) @(negedge clk); reload_val = 8'd19; end
        join
        check("R9 current low keeps old value", lo, 20);
        check("R9 next high uses new value", hi, 40);
    endtask

    task automatic t_collide();
        int lo, hi, lt, ht, ll, hl, guard = 0;
        do_reset();
        reload_val = 8'd9; wide_mode = 1'b1; enable = 1'b1;
        while (!(phase_tick && !scl_drive_low) && guard < 200) begin
            @(negedge clk); guard++;
        end
        reload_val = 8'd4;
        meas(lo, hi, lt, ht, ll, hl);
        check("R9 value changed at phase end, low", lo, 10);
        check("R9 value changed at phase end, high", hi, 10);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_basic();
        t_modes();
        t_clamp();
        t_stretch();
        t_midchange();
        t_collide();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule